// File: doc/BRIEF.md
# Multiplexed-Bus Flash Front-End

This block is the device side of a flash memory that shares one 8-bit bus for commands, addresses and data. It samples the bus strobes on the system clock. A rising write strobe latches a byte, and the two latch-select inputs decide whether that byte is a command, an address byte or a data byte. A rising read strobe advances an internal pointer, so a host can stream bytes out one at a time. Program, erase and read-setup commands start an internal operation. While that operation runs, a busy indication is shown as a pull-low request on a shared ready line, and its length comes from a per-operation cycle count.

The storage is a small behavioural byte array. Erased bytes read as 0xFF. After reset, byte i holds `i[7:0] ^ INIT_XOR`. A write-protect input blocks program and erase. When the chip is deselected, the block ignores all strobes, but an operation already running still counts down to its end. An optional power-on mode starts the block in read mode at address 0, so the first four sectors can be streamed with no command at all.

Top module: `flash_bus_frontend`

## Requirements
- R1: A byte is latched as a command on the clock edge that sees the rising write strobe with only the command select high. The command codes are 0x00 read setup, 0x80 program setup, 0x10 program confirm, 0x60 erase setup, 0xD0 erase confirm and 0x70 status read.
- R2: Each setup command is followed by ADDR_CYCLES (3) address bytes, latched with only the address select high. Together they form the pointer, low byte first. Pointer values at or above 2^DEPTH_W read as 0xFF and are never written.
- R3: After the last read address byte, the block stays busy for READ_CYC cycles. While the read strobe is low, the bus then shows the byte at the pointer, and each rising read strobe advances the pointer by one.
- R4: After program setup, each data byte (both selects low) is stored at the pointer, and the pointer then advances. Confirm 0x10 starts a busy period of PROG_CYC cycles. The stored bytes read back unchanged.
- R5: Erase confirm 0xD0 sets all 2^SECTOR_W bytes of the aligned sector that holds the pointer to 0xFF, with a busy period of ERASE_CYC cycles.
- R6: While the protect input is low, 0x80 and 0x60 are refused. The state and the array stay unchanged, and no busy period starts.
- R7: The busy output stays high for exactly the configured cycle count. It rises on the edge that latches the starting byte.
- R8: While busy, only 0x70 is accepted. All other commands, address bytes, data bytes and read advances are ignored.
- R9: In status mode the bus shows a status byte. Bit 7 is the protect input level, bit 6 is ready (not busy), bit 0 is the sequence-error flag, and the other bits are 0.
- R10: A write strobe with both selects high discards the byte and sets the sequence-error flag. The next accepted 0x00, 0x80 or 0x60 clears the flag.
- R11: The output enable is high only while the chip select and the read strobe are both low. Outside read mode (when ready) and outside status mode, the bus value is 0xFF.
- R12: While the chip select is high, write and read strobes are ignored. A busy period that is already running completes with its full length and its effect.
- R13: With AUTO_READ set, the block leaves reset in read mode at pointer 0 with no busy period, so the first four sectors stream out in order.
- R14: Out of reset, busy is low, the sequence-error flag is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, all strobes sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| cmd_lat | input | 1 | Marks the bus byte as a command |
| adr_lat | input | 1 | Marks the bus byte as an address byte |
| wstb_n | input | 1 | Write strobe, byte latched on its rise |
| rstb_n | input | 1 | Read strobe, drives the bus while low and advances on its rise |
| lock_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Bus byte into the block |
| io_out | output | 8 | Bus byte out of the block |
| io_oe | output | 1 | Bus output enable (high-impedance when low) |
| rb_low | output | 1 | Busy, a request to pull the shared ready line low |
| seq_err | output | 1 | Sticky flag for a strobe with both selects high |

## Verification
The main function is tried in several ways: streaming after power-on with no command, a read set up at an unaligned address, a read at an out-of-range address, and program and erase followed by readback. Together these separate correct pointer assembly and advance from an off-by-one or a wrong byte order. Refused and ignored stimulus (protect low, chip deselected, commands issued while busy) is each followed by a readback or a busy-length count. This shows whether the stimulus reached the array. Status bytes taken during and after a busy period, and after a sequence error, distinguish the individual status bits.

// File: rtl/flash_fe_pkg.sv
`timescale 1ns/100ps
package flash_fe_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_PDATA,
      ST_EWAIT,
      ST_READ,
      ST_STATUS
   } fe_state_e;

   typedef enum logic [1:0] {
      OP_RD,
      OP_PG,
      OP_ER
   } fe_op_e;

   localparam logic [7:0] C_READ   = 8'h00;
   localparam logic [7:0] C_PROG   = 8'h80;
   localparam logic [7:0] C_PCONF  = 8'h10;
   localparam logic [7:0] C_ERASE  = 8'h60;
   localparam logic [7:0] C_ECONF  = 8'hD0;
   localparam logic [7:0] C_STATUS = 8'h70;

endpackage

// File: rtl/fe_strobe_dec.sv
`timescale 1ns/100ps
module fe_strobe_dec (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_n,
   input  logic cmd_lat,
   input  logic adr_lat,
   input  logic wstb_n,
   input  logic rstb_n,
   output logic cmd_stb,
   output logic addr_stb,
   output logic data_stb,
   output logic err_stb,
   output logic rd_adv
);
   logic wstb_prev;
   logic rstb_prev;
   logic w_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wstb_prev <= 1'b1;
         rstb_prev <= 1'b1;
      end else begin
         wstb_prev <= wstb_n;
         rstb_prev <= rstb_n;
      end
   end

   assign w_rise   = ~sel_n & wstb_n & ~wstb_prev;
   assign err_stb  = w_rise &  cmd_lat &  adr_lat;
   assign cmd_stb  = w_rise &  cmd_lat & ~adr_lat;
   assign addr_stb = w_rise & ~cmd_lat &  adr_lat;
   assign data_stb = w_rise & ~cmd_lat & ~adr_lat;
   assign rd_adv   = ~sel_n & rstb_n & ~rstb_prev;

endmodule

// File: rtl/fe_busy_timer.sv
`timescale 1ns/100ps
module fe_busy_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

   // R7: a running period shortens by exactly one per cycle
   a_r7_busy_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/fe_cell_array.sv
`timescale 1ns/100ps
module fe_cell_array #(
   parameter int         DEPTH_W  = 7,
   parameter int         SECTOR_W = 3,
   parameter logic [7:0] INIT_XOR = 8'h5A
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [DEPTH_W-1:0]          wr_idx,
   input  logic [7:0]                  wr_data,
   input  logic                        ers_en,
   input  logic [DEPTH_W-SECTOR_W-1:0] ers_sec,
   input  logic [DEPTH_W-1:0]          rd_idx,
   output logic [7:0]                  rd_data
);
   localparam int DEPTH = 1 << DEPTH_W;
   localparam int SEC_W = DEPTH_W - SECTOR_W;

   logic [7:0] cells [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      localparam logic [7:0] RST_V = 8'(i) ^ INIT_XOR;
      logic [7:0] cell_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q <= RST_V;
         else if (wr_en && (wr_idx == DEPTH_W'(i)))
            cell_q <= wr_data;
         else if (ers_en && (ers_sec == SEC_W'(i >> SECTOR_W)))
            cell_q <= 8'hFF;
      end

      assign cells[i] = cell_q;
   end

   assign rd_data = cells[rd_idx];

endmodule

// File: rtl/flash_bus_frontend.sv
`timescale 1ns/100ps
module flash_bus_frontend
   import flash_fe_pkg::*;
#(
   parameter int         DEPTH_W     = 7,
   parameter int         SECTOR_W    = 3,
   parameter int         ADDR_CYCLES = 3,
   parameter int         CNT_W       = 16,
   parameter int         READ_CYC    = 6,
   parameter int         PROG_CYC    = 40,
   parameter int         ERASE_CYC   = 30,
   parameter bit         AUTO_READ   = 1'b1,
   parameter logic [7:0] INIT_XOR    = 8'h5A
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_n,
   input  logic       cmd_lat,
   input  logic       adr_lat,
   input  logic       wstb_n,
   input  logic       rstb_n,
   input  logic       lock_n,
   input  logic [7:0] io_in,
   output logic [7:0] io_out,
   output logic       io_oe,
   output logic       rb_low,
   output logic       seq_err
);
   localparam int PTR_W  = 8 * ADDR_CYCLES;
   localparam int ACNT_W = $clog2(ADDR_CYCLES + 1);
   localparam int SEC_W  = DEPTH_W - SECTOR_W;

   initial begin
      assert (DEPTH_W >= SECTOR_W + 2) else $error("array must hold four sectors");
      assert (DEPTH_W < PTR_W) else $error("pointer must exceed array index");
      assert (READ_CYC > 0 && PROG_CYC > 0 && ERASE_CYC > 0) else $error("cycle counts must be positive");
      assert (ERASE_CYC < (1 << CNT_W) && PROG_CYC < (1 << CNT_W) && READ_CYC < (1 << CNT_W))
         else $error("CNT_W too narrow");
   end

   // ---------------- reset-state variant ----------------
   fe_state_e st_rst;
   if (AUTO_READ) begin : g_auto
      assign st_rst = ST_READ;
   end else begin : g_manual
      assign st_rst = ST_IDLE;
   end

   // ---------------- strobe decode ----------------
   logic cmd_stb, addr_stb, data_stb, err_stb, rd_adv;

   fe_strobe_dec u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_n    (sel_n),
      .cmd_lat  (cmd_lat),
      .adr_lat  (adr_lat),
      .wstb_n   (wstb_n),
      .rstb_n   (rstb_n),
      .cmd_stb  (cmd_stb),
      .addr_stb (addr_stb),
      .data_stb (data_stb),
      .err_stb  (err_stb),
      .rd_adv   (rd_adv)
   );

   // ---------------- state ----------------
   fe_state_e         st_q;
   fe_op_e            op_q;
   logic [PTR_W-1:0]  ptr_q;
   logic [ACNT_W-1:0] acnt_q;
   logic              err_q;
   logic              busy;

   logic last_a, in_range;
   logic go_read, go_pconf, go_econf, go_store;
   logic tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic [7:0] arr_rd;

   assign last_a   = (acnt_q == ACNT_W'(ADDR_CYCLES - 1));
   assign in_range = ~|ptr_q[PTR_W-1:DEPTH_W];

   assign go_read  = addr_stb & ~busy & (st_q == ST_ADDR) & last_a & (op_q == OP_RD);
   assign go_pconf = cmd_stb & ~busy & (io_in == C_PCONF) & (st_q == ST_PDATA);
   assign go_econf = cmd_stb & ~busy & (io_in == C_ECONF) & (st_q == ST_EWAIT);
   assign go_store = data_stb & ~busy & (st_q == ST_PDATA);

   assign tmr_load = go_read | go_pconf | go_econf;
   assign tmr_val  = go_pconf ? CNT_W'(PROG_CYC) :
                     go_econf ? CNT_W'(ERASE_CYC) : CNT_W'(READ_CYC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= st_rst;
         op_q   <= OP_RD;
         ptr_q  <= '0;
         acnt_q <= '0;
         err_q  <= 1'b0;
      end else begin
         if (err_stb)
            err_q <= 1'b1;
         if (cmd_stb) begin
            if (io_in == C_STATUS) begin
               st_q <= ST_STATUS;
            end else if (!busy) begin
               case (io_in)
                  C_READ: begin
                     st_q <= ST_ADDR; op_q <= OP_RD;
                     ptr_q <= '0; acnt_q <= '0; err_q <= 1'b0;
                  end
                  C_PROG: if (lock_n) begin
                     st_q <= ST_ADDR; op_q <= OP_PG;
                     ptr_q <= '0; acnt_q <= '0; err_q <= 1'b0;
                  end
                  C_ERASE: if (lock_n) begin
                     st_q <= ST_ADDR; op_q <= OP_ER;
                     ptr_q <= '0; acnt_q <= '0; err_q <= 1'b0;
                  end
                  C_PCONF: if (st_q == ST_PDATA) st_q <= ST_IDLE;
                  C_ECONF: if (st_q == ST_EWAIT) st_q <= ST_IDLE;
                  default: ;
               endcase
            end
         end else if (addr_stb && !busy && st_q == ST_ADDR) begin
            for (int b = 0; b < ADDR_CYCLES; b++)
               if (acnt_q == ACNT_W'(b))
                  ptr_q[8*b +: 8] <= io_in;
            acnt_q <= acnt_q + 1'b1;
            if (last_a) begin
               case (op_q)
                  OP_PG:   st_q <= ST_PDATA;
                  OP_ER:   st_q <= ST_EWAIT;
                  default: st_q <= ST_READ;
               endcase
            end
         end else if (go_store) begin
            ptr_q <= ptr_q + 1'b1;
         end else if (rd_adv && !busy && st_q == ST_READ) begin
            ptr_q <= ptr_q + 1'b1;
         end
      end
   end

   // ---------------- busy timer and array ----------------
   fe_busy_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .busy     (busy)
   );

   fe_cell_array #(
      .DEPTH_W  (DEPTH_W),
      .SECTOR_W (SECTOR_W),
      .INIT_XOR (INIT_XOR)
   ) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (go_store & in_range),
      .wr_idx  (ptr_q[DEPTH_W-1:0]),
      .wr_data (io_in),
      .ers_en  (go_econf & in_range),
      .ers_sec (ptr_q[DEPTH_W-1:SECTOR_W]),
      .rd_idx  (ptr_q[DEPTH_W-1:0]),
      .rd_data (arr_rd)
   );

   // ---------------- bus outputs ----------------
   logic [7:0] status_b;
   assign status_b = {lock_n, ~busy, 5'b0, err_q};

   always_comb begin
      if (st_q == ST_STATUS)
         io_out = status_b;
      else if (st_q == ST_READ && !busy && in_range)
         io_out = arr_rd;
      else
         io_out = 8'hFF;
   end

   assign io_oe   = ~sel_n & ~rstb_n;
   assign rb_low  = busy;
   assign seq_err = err_q;

   // ---------------- assertions ----------------
   // R8: strobes other than status are ignored while busy
   a_r8_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (addr_stb || data_stb || (cmd_stb && io_in != C_STATUS)))
      |=> ($stable(st_q) && $stable(ptr_q)));

   // R6: protected program/erase setup leaves the state alone
   a_r6_lock_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb && !lock_n && !busy && (io_in == C_PROG || io_in == C_ERASE))
      |=> ($stable(st_q) && !busy));

   // R10: a double-select strobe sets the flag
   a_r10_err_set: assert property (@(posedge clk) disable iff (!rst_n)
      err_stb |=> seq_err);

   // R12: deselected and idle means nothing moves
   a_r12_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n && !busy) |=> ($stable(st_q) && $stable(ptr_q) && !busy));

endmodule

// File: tb/flash_bus_frontend_bench.sv
`timescale 1ns/100ps
module flash_bus_frontend_bench;
   localparam int         READ_CYC  = 6;
   localparam int         PROG_CYC  = 40;
   localparam int         ERASE_CYC = 30;
   localparam logic [7:0] XR        = 8'h5A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_n = 1'b0;
   logic       cmd_lat = 1'b0;
   logic       adr_lat = 1'b0;
   logic       wstb_n = 1'b1;
   logic       rstb_n = 1'b1;
   logic       lock_n = 1'b1;
   logic [7:0] io_in = 8'h00;
   logic [7:0] io_out;
   logic       io_oe, rb_low, seq_err;

   always #2.5 clk = ~clk;

   flash_bus_frontend #(
      .DEPTH_W(7), .SECTOR_W(3), .ADDR_CYCLES(3), .CNT_W(16),
      .READ_CYC(READ_CYC), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
      .AUTO_READ(1'b1), .INIT_XOR(XR)
   ) u_flash_bus_frontend (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .cmd_lat(cmd_lat),
      .adr_lat(adr_lat), .wstb_n(wstb_n), .rstb_n(rstb_n), .lock_n(lock_n),
      .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .rb_low(rb_low),
      .seq_err(seq_err)
   );

   int n_chk = 0;
   int n_err = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   // scoreboard monitor: one sample per read-strobe low phase
   always @(negedge clk) begin
      if (rst_n && !sel_n && !rstb_n && exp_q.size() > 0) begin
         automatic logic [7:0] e = exp_q.pop_front();
         automatic string t = tag_q.pop_front();
         check(t, io_out, e);
         check({t, " R11 oe"}, io_oe, 1);
      end
   end

   task automatic wr(input logic c, input logic a, input logic [7:0] b);
      @(posedge clk); #1;
      cmd_lat = c; adr_lat = a; io_in = b; wstb_n = 1'b0;
      @(posedge clk); #1 wstb_n = 1'b1;
      @(posedge clk); #1 cmd_lat = 1'b0; adr_lat = 1'b0;
   endtask

   task automatic cmd(input logic [7:0] b);
      wr(1'b1, 1'b0, b);
   endtask

   task automatic adr(input logic [23:0] a);
      wr(1'b0, 1'b1, a[7:0]);
      wr(1'b0, 1'b1, a[15:8]);
      wr(1'b0, 1'b1, a[23:16]);
   endtask

   task automatic rd(input logic [7:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(posedge clk); #1 rstb_n = 1'b0;
      @(posedge clk); #1 rstb_n = 1'b1;
   endtask

   task automatic busy_len(output int n);
      n = 0;
      forever begin
         @(negedge clk);
         if (rb_low) n++;
         else break;
      end
   endtask

   task automatic do_read(input logic [23:0] a);
      int n;
      cmd(8'h00);
      adr(a);
      busy_len(n);
      check("R3 read busy length", n, READ_CYC);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int n;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R14
      check("R14 busy after reset", rb_low, 0);
      check("R14 seq_err after reset", seq_err, 0);
      check("R14 oe after reset", io_oe, 0);

      // R13: auto-read of the first four sectors
      for (int i = 0; i < 32; i++) rd(8'(i) ^ XR, "R13 auto-read");

      // R11: bus enable needs both select and read strobe low
      @(posedge clk); #1 sel_n = 1'b1; rstb_n = 1'b0;
      @(negedge clk) check("R11 oe deselected", io_oe, 0);
      @(posedge clk); #1 sel_n = 1'b0; rstb_n = 1'b1;
      @(negedge clk) check("R11 oe strobe high", io_oe, 0);

      // R1 R2 R3: read at unaligned address, low byte first
      do_read(24'h000013);
      for (int i = 0; i < 5; i++) rd(8'(8'h13 + i) ^ XR, "R1 R2 R3 stream");
      do_read(24'h000105);
      rd(8'hFF, "R2 out of range");

      // R4: program and read back
      cmd(8'h80); adr(24'h000040);
      wr(1'b0, 1'b0, 8'hAA); wr(1'b0, 1'b0, 8'h55);
      wr(1'b0, 1'b0, 8'h0F); wr(1'b0, 1'b0, 8'hF0);
      cmd(8'h10);
      busy_len(n);
      check("R4 R7 program busy length", n, PROG_CYC);
      rd(8'hFF, "R11 idle bus value");
      do_read(24'h000040);
      rd(8'hAA, "R4 readback"); rd(8'h55, "R4 readback");
      rd(8'h0F, "R4 readback"); rd(8'hF0, "R4 readback");

      // R6 R9: protect low
      lock_n = 1'b0;
      cmd(8'h70);
      rd(8'h40, "R9 status protected");
      cmd(8'h80); adr(24'h000044); wr(1'b0, 1'b0, 8'h99); cmd(8'h10);
      busy_len(n);
      check("R6 no busy when protected", n, 0);
      lock_n = 1'b1;
      do_read(24'h000044);
      rd(8'h44 ^ XR, "R6 array unchanged");

      // R5 R12: erase, deselect during busy
      cmd(8'h60); adr(24'h000042); cmd(8'hD0);
      sel_n = 1'b1;
      busy_len(n);
      check("R5 R12 erase busy length", n, ERASE_CYC);
      sel_n = 1'b0;
      do_read(24'h000040);
      for (int i = 0; i < 8; i++) rd(8'hFF, "R5 sector erased");

      // R12: strobes ignored while deselected
      sel_n = 1'b1;
      cmd(8'h80); adr(24'h000048); wr(1'b0, 1'b0, 8'h11); cmd(8'h10);
      busy_len(n);
      check("R12 no busy when deselected", n, 0);
      sel_n = 1'b0;
      do_read(24'h000048);
      rd(8'h48 ^ XR, "R12 array unchanged");

      // R8 R9: commands during busy
      cmd(8'h80); adr(24'h000050);
      wr(1'b0, 1'b0, 8'h12); wr(1'b0, 1'b0, 8'h34);
      cmd(8'h10);
      cmd(8'h60); adr(24'h000050); cmd(8'hD0);
      cmd(8'h70);
      check("R7 still busy", rb_low, 1);
      rd(8'h80, "R8 R9 status while busy");
      while (rb_low) @(negedge clk);
      rd(8'hC0, "R9 status ready");
      do_read(24'h000050);
      rd(8'h12, "R8 erase ignored"); rd(8'h34, "R8 erase ignored");

      // R10: sequence error
      cmd(8'h70);
      wr(1'b1, 1'b1, 8'h55);
      check("R10 flag set", seq_err, 1);
      rd(8'hC1, "R10 status bit0");
      cmd(8'h00);
      check("R10 flag cleared", seq_err, 0);
      adr(24'h000000);
      while (rb_low) @(negedge clk);

      repeat (3) @(posedge clk);
      finish_run();
   end

endmodule